// File: doc/BRIEF.md
# Transport Packet Ring Writer

This block takes fixed-length transport packets, 188 bytes each, from one channel's input stream. The stream is presented as 64-bit beats. The block stores each packet into a circular buffer in system memory. Every packet fills one slot, which is the packet length rounded up to a whole number of 8-byte beats, so a slot is 192 bytes (24 beats). Software describes the ring with a start address and an inclusive end address. The block owns the write pointer and moves it forward one slot each time a slot is complete. The consumer owns the read pointer and advances it as it drains data.

The block never overruns the consumer. If storing the next packet would make the write pointer land on the read pointer, the whole packet is consumed and discarded, and a sticky overflow flag is raised. A channel enable stops new packets from being accepted. An idle request word, carrying a global request flag and one bit per channel, raises an interrupt once this channel is disabled and holds no partially written packet. Software then clears the request by writing zero.

Top module: `ring_pkt_writer`

## Requirements
- R1: After reset, every register reads zero, all three flags are low, and `inReady` is low.
- R2: The register map uses word addresses on `regAddr`: 0 ring start, 1 ring inclusive end, 2 write pointer (read-only), 3 read pointer, 4 enable (bit 0), 5 idle request, 6 status. A write to address 0 also loads both the write pointer and the read pointer with the same value.
- R3: Beat b of a stored packet is written to write pointer + 8*b, with the input beat as data. The write pointer advances by 192 only in the cycle the 24th beat is accepted by memory, so packets occupy consecutive slots in arrival order.
- R4: When write pointer + 192 exceeds the inclusive end address, the next write pointer is the ring start instead.
- R5: When the next write pointer would equal the read pointer, the packet's 24 beats are accepted with no memory write. The write pointer stays unchanged and the overflow flag is set.
- R6: Status bit 0 (data available) is set whenever a slot is committed. Status bit 1 is overflow. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. The two bits are also driven on `availFlag` and `ovfFlag`.
- R7: With enable at 0, no new packet is accepted (`inReady` low). A packet already in progress when enable drops is completed and committed.
- R8: `idleIrq` is high exactly when the idle request word has bit 31 and bit CHAN_ID set, the enable is 0, and no packet is in progress. Reading address 5 returns the written word, and writing 0 to it removes the interrupt.
- R9: While `memReady` is low on a stored packet, `inReady` is low and no beat is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 3 | Register word address |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Read data for `regAddr`, same cycle |
| inValid | input | 1 | Input beat valid |
| inData | input | DATA_W | Input beat |
| inReady | output | 1 | Input beat accepted when high with `inValid` |
| memValid | output | 1 | Memory write request |
| memAddr | output | REG_W | Memory byte address |
| memData | output | DATA_W | Memory write data |
| memReady | input | 1 | Memory accepts the write |
| idleIrq | output | 1 | Idle interrupt (level) |
| availFlag | output | 1 | Sticky data-available flag |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
Register reads return combinationally, so the bench samples `regRdata` one time step after it drives the address at a falling edge. A register write, a slot commit, a flag change and an `idleIrq` change all take effect on the first rising edge after the stimulus. Each check is therefore taken at the next falling edge. A packet's final pointer and memory contents are checked at the falling edge after its 24th accepted beat. The memory model stores on the same rising edge that completes the handshake.

// File: rtl/ring_pkt_writer_pkg.sv
package ring_pkt_writer_pkg;

  // Register word addresses
  typedef enum logic [2:0] {
    RA_START = 3'd0,
    RA_END   = 3'd1,
    RA_WPTR  = 3'd2,
    RA_RPTR  = 3'd3,
    RA_CTRL  = 3'd4,
    RA_IDLE  = 3'd5,
    RA_STAT  = 3'd6
  } regAddr_e;

  // Strobes from control to the register/datapath side
  typedef struct packed {
    logic writeBeat;  // a beat is written to memory this cycle
    logic commit;     // last beat of a stored packet written this cycle
    logic dropStart;  // first beat of a discarded packet accepted this cycle
  } ringStrobe_t;

endpackage

// File: rtl/ring_wr_ctrl.sv
module ring_wr_ctrl
  import ring_pkt_writer_pkg::*;
#(
  parameter int SLOT_BEATS = 24,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             memReady,
  input  logic             chanEn,
  input  logic             ringFull,
  output logic             inReady,
  output logic             memValid,
  output logic [CNT_W-1:0] beatIdx,
  output logic             busy,
  output ringStrobe_t      strobe
);

  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(SLOT_BEATS - 1);

  logic             busyQ;
  logic             dropQ;
  logic [CNT_W-1:0] cntQ;
  logic             curDrop;
  logic             active;
  logic             accept;
  logic             lastBeat;

  // Drop decision is taken at the first beat and held for the packet
  assign curDrop  = busyQ ? dropQ : ringFull;
  assign active   = busyQ | chanEn;
  assign inReady  = active & (curDrop | memReady);
  assign memValid = active & inValid & ~curDrop;
  assign accept   = inValid & inReady;
  assign lastBeat = (cntQ == LAST_BEAT);

  assign strobe.writeBeat = accept & ~curDrop;
  assign strobe.commit    = accept & ~curDrop & lastBeat;
  assign strobe.dropStart = accept & ~busyQ & ringFull;

  assign beatIdx = cntQ;
  assign busy    = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      dropQ <= 1'b0;
      cntQ  <= '0;
    end else if (accept) begin
      if (lastBeat) begin
        busyQ <= 1'b0;
        dropQ <= 1'b0;
        cntQ  <= '0;
      end else begin
        busyQ <= 1'b1;
        dropQ <= curDrop;
        cntQ  <= cntQ + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ring_wr_regs.sv
module ring_wr_regs
  import ring_pkt_writer_pkg::*;
#(
  parameter int REG_W         = 32,
  parameter int CNT_W         = 5,
  parameter int SLOT_BYTES    = 192,
  parameter int BEAT_BYTES    = 8,
  parameter int CHAN_ID       = 0,
  parameter int IDLE_FLAG_BIT = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regValid,
  input  logic             regWrite,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  ringStrobe_t      strobe,
  input  logic [CNT_W-1:0] beatIdx,
  input  logic             busy,
  output logic [REG_W-1:0] memAddr,
  output logic             ringFull,
  output logic             chanEn,
  output logic             idleIrq,
  output logic             availFlag,
  output logic             ovfFlag
);

  logic [REG_W-1:0] startQ, endQ, wpQ, rpQ, idleQ;
  logic             enQ, availQ, ovfQ;
  logic [REG_W:0]   sumWide;
  logic             wrapNext;
  logic [REG_W-1:0] nextWp;
  logic             wrEn;

  // Next slot position with wrap at the inclusive end
  assign sumWide  = {1'b0, wpQ} + (REG_W+1)'(SLOT_BYTES);
  assign wrapNext = sumWide > {1'b0, endQ};
  assign nextWp   = wrapNext ? startQ : sumWide[REG_W-1:0];
  assign ringFull = (nextWp == rpQ);

  assign memAddr  = wpQ + REG_W'(beatIdx) * REG_W'(BEAT_BYTES);
  assign wrEn     = regValid & regWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      endQ   <= '0;
      wpQ    <= '0;
      rpQ    <= '0;
      idleQ  <= '0;
      enQ    <= 1'b0;
      availQ <= 1'b0;
      ovfQ   <= 1'b0;
    end else begin
      if (wrEn) begin
        case (regAddr)
          RA_START: begin
            startQ <= regWdata;
            wpQ    <= regWdata;
            rpQ    <= regWdata;
          end
          RA_END:  endQ  <= regWdata;
          RA_RPTR: rpQ   <= regWdata;
          RA_CTRL: enQ   <= regWdata[0];
          RA_IDLE: idleQ <= regWdata;
          RA_STAT: begin
            if (regWdata[0]) availQ <= 1'b0;
            if (regWdata[1]) ovfQ   <= 1'b0;
          end
          default: ;
        endcase
      end
      // Hardware events win over a same-cycle software write
      if (strobe.commit) begin
        wpQ    <= nextWp;
        availQ <= 1'b1;
      end
      if (strobe.dropStart) ovfQ <= 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      RA_START: regRdata = startQ;
      RA_END:   regRdata = endQ;
      RA_WPTR:  regRdata = wpQ;
      RA_RPTR:  regRdata = rpQ;
      RA_CTRL:  regRdata = REG_W'(enQ);
      RA_IDLE:  regRdata = idleQ;
      RA_STAT:  regRdata = REG_W'({ovfQ, availQ});
      default:  regRdata = '0;
    endcase
  end

  assign chanEn    = enQ;
  assign availFlag = availQ;
  assign ovfFlag   = ovfQ;
  assign idleIrq   = idleQ[IDLE_FLAG_BIT] & idleQ[CHAN_ID] & ~enQ & ~busy;

endmodule

// File: rtl/ring_pkt_writer.sv
module ring_pkt_writer
  import ring_pkt_writer_pkg::*;
#(
  parameter int DATA_W        = 64,
  parameter int REG_W         = 32,
  parameter int PKT_BYTES     = 188,
  parameter int CHAN_ID       = 0,
  parameter int IDLE_FLAG_BIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              memValid,
  output logic [REG_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memReady,
  output logic              idleIrq,
  output logic              availFlag,
  output logic              ovfFlag
);

  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int SLOT_BEATS = (PKT_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;
  localparam int SLOT_BYTES = SLOT_BEATS * BEAT_BYTES;
  localparam int CNT_W      = (SLOT_BEATS > 1) ? $clog2(SLOT_BEATS) : 1;

  ringStrobe_t      strobeS;
  logic [CNT_W-1:0] beatIdxS;
  logic             busyS;
  logic             ringFullS;
  logic             chanEnS;

  ring_wr_ctrl #(
    .SLOT_BEATS (SLOT_BEATS),
    .CNT_W      (CNT_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .memReady (memReady),
    .chanEn   (chanEnS),
    .ringFull (ringFullS),
    .inReady  (inReady),
    .memValid (memValid),
    .beatIdx  (beatIdxS),
    .busy     (busyS),
    .strobe   (strobeS)
  );

  ring_wr_regs #(
    .REG_W         (REG_W),
    .CNT_W         (CNT_W),
    .SLOT_BYTES    (SLOT_BYTES),
    .BEAT_BYTES    (BEAT_BYTES),
    .CHAN_ID       (CHAN_ID),
    .IDLE_FLAG_BIT (IDLE_FLAG_BIT)
  ) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .regValid  (regValid),
    .regWrite  (regWrite),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .strobe    (strobeS),
    .beatIdx   (beatIdxS),
    .busy      (busyS),
    .memAddr   (memAddr),
    .ringFull  (ringFullS),
    .chanEn    (chanEnS),
    .idleIrq   (idleIrq),
    .availFlag (availFlag),
    .ovfFlag   (ovfFlag)
  );

  assign memData = inData;

endmodule

// File: rtl/ring_pkt_writer_chk.sv
module ring_pkt_writer_chk
  import ring_pkt_writer_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int BEAT_BYTES = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             memValid,
  input logic [REG_W-1:0] memAddr,
  input logic             regValid,
  input logic             regWrite,
  input logic             idleIrq,
  input logic             ovfFlag,
  input logic             availFlag,
  input logic             busy,
  input logic             chanEn,
  input ringStrobe_t      strobe
);

  // R7
  disabled_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !chanEn) |-> !inReady);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleIrq |-> (!memValid && !inReady));

  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(inValid && inReady && !busy));

  // R6
  avail_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> availFlag);

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeBeat && !strobe.commit && !(regValid && regWrite))
      |=> (memAddr == $past(memAddr) + REG_W'(BEAT_BYTES)));

endmodule

bind ring_pkt_writer ring_pkt_writer_chk #(
  .REG_W      (REG_W),
  .BEAT_BYTES (DATA_W / 8)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .memValid  (memValid),
  .memAddr   (memAddr),
  .regValid  (regValid),
  .regWrite  (regWrite),
  .idleIrq   (idleIrq),
  .ovfFlag   (ovfFlag),
  .availFlag (availFlag),
  .busy      (busyS),
  .chanEn    (chanEnS),
  .strobe    (strobeS)
);

// File: tb/tb_ring_pkt_writer.sv
module tb_ring_pkt_writer;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 64;
  localparam int REG_W      = 32;
  localparam int CHAN       = 2;
  localparam int BEATS      = 24;
  localparam int SLOT       = 192;
  localparam int NSLOT      = 8;
  localparam int SIZE       = SLOT * NSLOT;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] TOP  = BASE + SIZE - 1;
  localparam logic [31:0] FLAG = 32'h8000_0000;
  localparam logic [63:0] SENT = 64'hDEAD_BEEF_DEAD_BEEF;

  logic              clk = 1'b0;
  logic              rstN;
  logic              regValid, regWrite;
  logic [2:0]        regAddr;
  logic [REG_W-1:0]  regWdata, regRdata;
  logic              inValid, inReady;
  logic [DATA_W-1:0] inData;
  logic              memValid, memReady;
  logic [REG_W-1:0]  memAddr;
  logic [DATA_W-1:0] memData;
  logic              idleIrq, availFlag, ovfFlag;
  logic              stallMode;

  int checks = 0;
  int errors = 0;
  int outOfRange = 0;

  logic [63:0] mem [0:SIZE/8-1];
  logic [31:0] memOff;

  ring_pkt_writer #(.CHAN_ID(CHAN)) dut (
    .clk(clk), .rstN(rstN),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .memValid(memValid), .memAddr(memAddr), .memData(memData), .memReady(memReady),
    .idleIrq(idleIrq), .availFlag(availFlag), .ovfFlag(ovfFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memOff = memAddr - BASE;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SIZE/8; i++) mem[i] <= SENT;
    end else if (memValid && memReady) begin
      if (memOff < SIZE) mem[memOff/8] <= memData;
      else outOfRange <= outOfRange + 1;
    end
  end

  initial memReady = 1'b1;
  always @(negedge clk) memReady <= stallMode ? ~memReady : 1'b1;

  task automatic finish();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
    regValid = 1'b0;
  endtask

  function automatic logic [63:0] beatVal(input int tag, input int b);
    return {tag[31:0], 16'hA5A5, b[15:0]};
  endfunction

  task automatic sendPkt(input int tag);
    for (int b = 0; b < BEATS; b++) begin
      @(negedge clk);
      inValid = 1'b1; inData = beatVal(tag, b);
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkSlot(input string req, input int slot, input int tag);
    int bad = 0;
    for (int b = 0; b < BEATS; b++)
      if (mem[slot*BEATS+b] !== beatVal(tag, b)) bad++;
    checkEq(req, $sformatf("slot %0d bad beats (tag %0d)", slot, tag), 64'(bad), 64'd0);
  endtask

  task automatic checkUntouched(input string req, input int slot);
    int bad = 0;
    for (int b = 0; b < BEATS; b++)
      if (mem[slot*BEATS+b] !== SENT) bad++;
    checkEq(req, $sformatf("slot %0d written beats", slot), 64'(bad), 64'd0);
  endtask

  task automatic checkWp(input string req, input logic [31:0] exp);
    logic [31:0] v;
    regRd(3'd2, v);
    checkEq(req, "write pointer", 64'(v), 64'(exp));
  endtask

  task automatic tReset();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      regRd(3'(a), v);
      checkEq("R1", $sformatf("reg %0d after reset", a), 64'(v), 64'd0);
    end
    checkEq("R1", "flags/irq/ready", {60'd0, idleIrq, availFlag, ovfFlag, inReady}, 64'd0);
  endtask

  task automatic tConfig();
    logic [31:0] v;
    regWr(3'd0, BASE);
    regWr(3'd1, TOP);
    regRd(3'd2, v); checkEq("R2", "wp after start write", 64'(v), 64'(BASE));
    regRd(3'd3, v); checkEq("R2", "rp after start write", 64'(v), 64'(BASE));
    regRd(3'd1, v); checkEq("R2", "end register", 64'(v), 64'(TOP));
  endtask

  task automatic tGate();
    @(negedge clk); inValid = 1'b1; inData = '0;
    #1 checkEq("R7", "inReady while disabled", 64'(inReady), 64'd0);
    @(negedge clk);
    #1 checkEq("R7", "inReady while disabled, later", 64'(inReady), 64'd0);
    inValid = 1'b0;
    checkEq("R7", "no memory write while disabled", 64'(outOfRange), 64'd0);
  endtask

  task automatic tOrder();
    regWr(3'd4, 32'd1);
    sendPkt(1);
    checkWp("R3", BASE + SLOT);
    checkEq("R6", "avail after first commit", 64'(availFlag), 64'd1);
    sendPkt(2);
    sendPkt(3);
    checkWp("R3", BASE + 3*SLOT);
    checkSlot("R3", 0, 1);
    checkSlot("R3", 1, 2);
    checkSlot("R3", 2, 3);
  endtask

  task automatic tFull();
    for (int t = 4; t <= 7; t++) sendPkt(t);
    checkWp("R3", BASE + 7*SLOT);
    checkEq("R5", "ovf before full", 64'(ovfFlag), 64'd0);
    sendPkt(8);
    checkWp("R5", BASE + 7*SLOT);
    checkEq("R5", "ovf after drop", 64'(ovfFlag), 64'd1);
    checkUntouched("R5", 7);
  endtask

  task automatic tWrap();
    regWr(3'd3, BASE + 2*SLOT);
    sendPkt(9);
    checkSlot("R4", 7, 9);
    checkWp("R4", BASE);
    sendPkt(10);
    checkSlot("R4", 0, 10);
    checkWp("R4", BASE + SLOT);
    sendPkt(11);
    checkWp("R5", BASE + SLOT);
    checkSlot("R5", 1, 2);
  endtask

  task automatic tStatus();
    logic [31:0] v;
    regWr(3'd6, 32'd0);
    regRd(3'd6, v); checkEq("R6", "status after writing 0", 64'(v), 64'd3);
    regWr(3'd6, 32'd2);
    regRd(3'd6, v); checkEq("R6", "status after clearing ovf", 64'(v), 64'd1);
    regWr(3'd6, 32'd1);
    checkEq("R6", "avail pin cleared", 64'(availFlag), 64'd0);
  endtask

  task automatic tStall();
    regWr(3'd3, BASE + SLOT);
    stallMode = 1'b1;
    sendPkt(12);
    stallMode = 1'b0;
    checkSlot("R9", 1, 12);
    checkWp("R9", BASE + 2*SLOT);
    checkEq("R9", "no stray writes", 64'(outOfRange), 64'd0);
  endtask

  task automatic tMidDisable();
    fork
      sendPkt(13);
      begin
        repeat (5) @(negedge clk);
        regWr(3'd4, 32'd0);
      end
    join
    checkSlot("R7", 2, 13);
    checkWp("R7", BASE + 3*SLOT);
    @(negedge clk); inValid = 1'b1;
    #1 checkEq("R7", "inReady after disable", 64'(inReady), 64'd0);
    inValid = 1'b0;
  endtask

  task automatic tIdle();
    logic [31:0] v;
    logic [31:0] req = FLAG | (32'd1 << CHAN);
    regWr(3'd4, 32'd1);
    regWr(3'd5, req);
    checkEq("R8", "irq while enabled", 64'(idleIrq), 64'd0);
    regWr(3'd4, 32'd0);
    checkEq("R8", "irq once disabled", 64'(idleIrq), 64'd1);
    regRd(3'd5, v); checkEq("R8", "idle word readback", 64'(v), 64'(req));
    regWr(3'd5, FLAG | 32'd2);
    checkEq("R8", "irq for other channel", 64'(idleIrq), 64'd0);
    regWr(3'd5, 32'd1 << CHAN);
    checkEq("R8", "irq without global flag", 64'(idleIrq), 64'd0);
    regWr(3'd5, req);
    checkEq("R8", "irq re-requested", 64'(idleIrq), 64'd1);
    regWr(3'd5, 32'd0);
    checkEq("R8", "irq after clear", 64'(idleIrq), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    rstN = 1'b0; regValid = 1'b0; regWrite = 1'b0; regAddr = '0; regWdata = '0;
    inValid = 1'b0; inData = '0; stallMode = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tConfig();
    tGate();
    tOrder();
    tFull();
    tWrap();
    tStatus();
    tStall();
    tMidDisable();
    tIdle();
    repeat (2) @(negedge clk);
    finish();
  end

endmodule